// File: doc/BRIEF.md
# Windowed Register File

This block is an integer register file whose registers are grouped into a ring of banks, called windows. Software always addresses 32 registers. A current-window pointer (CWP) chooses which physical bank those 32 names refer to. A procedure call moves the pointer forward to a fresh bank, so the caller's registers stay untouched without any save. A return moves the pointer back to the caller's bank. The file has two combinational read ports and one synchronous write port.

The block counts how many windows behind the current one hold live data. A call that would reuse a live window is refused and raises `overflow`. Outside logic is then expected to spill one window to memory and pulse `spill_done`. A return with no live window behind it is refused and raises `underflow`. Outside logic then restores a window and pulses `fill_done`. After either pulse the refused call or return can be presented again. The trap machinery and the spill or fill memory traffic live outside this block.

The interfaces are plain control, address and data pins with no valid/ready handshake. A register write always completes in the cycle it is issued, and a read is returned in the same cycle. The only flow control is the call/return refusal described above, which is reported on `overflow` and `underflow`.

Top module: `regwin_file`

## Requirements
- R1: Register index 0 reads as zero on both read ports in every window, and a write to index 0 changes no register.
- R2: A call is accepted when `live_count` is below NWIN-1. On the next edge `cwp` becomes `cwp`+1, wrapping from NWIN-1 to 0, and `live_count` rises by one.
- R3: A call presented while `live_count` equals NWIN-1 drives `overflow` high in that same cycle. The call leaves `cwp` and the register contents unchanged.
- R4: A return presented without a call while `live_count` is 0 drives `underflow` high in that same cycle. The return leaves `cwp` unchanged.
- R5: An accepted return moves `cwp` to `cwp`-1 on the next edge, wrapping from 0 to NWIN-1, and lowers `live_count` by one.
- R6: When call and return are requested in the same cycle, the return is ignored and the call is handled as if presented alone. `underflow` stays low in that cycle.
- R7: A write lands in the register named by `wr_addr` of the window that is current in the write cycle, even when a call or return moves `cwp` at the same edge. Reads return the current window's contents in the same cycle. A window's registers are not visible through any other window.
- R8: `spill_done` and `fill_done` only act in a cycle with no accepted call or return. `spill_done` lowers `live_count` by one when it is above 0. Otherwise `fill_done` raises it by one when it is below NWIN-1. `spill_done` takes precedence over `fill_done`.
- R9: After reset, `cwp` is 0, `live_count` is 0, and `overflow` and `underflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Request to advance to a new window |
| ret_req | input | 1 | Request to go back to the caller's window |
| spill_done | input | 1 | One window has been saved to memory |
| fill_done | input | 1 | One window has been restored from memory |
| rd_addr_a | input | 5 | Register index for read port A |
| rd_data_a | output | XLEN | Read port A data |
| rd_addr_b | input | 5 | Register index for read port B |
| rd_data_b | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register index to write |
| wr_data | input | XLEN | Write data |
| cwp | output | $clog2(NWIN) | Current-window pointer |
| live_count | output | $clog2(NWIN) | Number of live windows behind the current one |
| overflow | output | 1 | A call was refused for lack of a free window |
| underflow | output | 1 | A return was refused for lack of a live window |

## Verification
Two pairs of functions can coincide in one cycle. A register write can meet a call or return that moves the pointer. A call request can meet a return request, or a spill/fill notice. The random phase issues writes on roughly half of all cycles and raises call, return, spill and fill independently, so these collisions happen often. Directed steps also force a write on the same edge as a call, and a call together with a return while the window stack is both full and empty. A reference model applies the acceptance and precedence rules for each cycle. It keeps a shadow copy of every window, and that copy is compared with both read ports once the pointer has moved, which shows whether a write went to the window that was current before the move.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  // Register index width seen by software (32 architectural names)
  localparam int unsigned ARCH_REGS = 32;
  localparam int unsigned IDX_W     = $clog2(ARCH_REGS);

  // What the pointer does at the next edge
  typedef enum logic [1:0] {
    WIN_HOLD = 2'd0,
    WIN_PUSH = 2'd1,
    WIN_POP  = 2'd2
  } win_move_e;

  // How the live-window counter is adjusted by spill/fill notices
  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_DEC  = 2'd1,
    ADJ_INC  = 2'd2
  } cnt_adj_e;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic          spill_done,
  input  logic          fill_done,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] live_count,
  output logic          overflow,
  output logic          underflow
);
  localparam logic [CW-1:0] TOP  = CW'(NWIN - 1);
  localparam logic [CW-1:0] ZERO = '0;

  logic      full, empty;
  win_move_e move;
  cnt_adj_e  adj;

  assign full  = (live_count == TOP);
  assign empty = (live_count == ZERO);

  // Decide the move; a call masks a simultaneous return
  always_comb begin
    move      = WIN_HOLD;
    overflow  = 1'b0;
    underflow = 1'b0;
    if (call_req) begin
      if (full) overflow = 1'b1;
      else      move     = WIN_PUSH;
    end else if (ret_req) begin
      if (empty) underflow = 1'b1;
      else       move      = WIN_POP;
    end
  end

  // Spill/fill notices only count in cycles without a pointer move
  always_comb begin
    adj = ADJ_NONE;
    if (move == WIN_HOLD) begin
      if (spill_done) begin
        if (!empty) adj = ADJ_DEC;
      end else if (fill_done && !full) begin
        adj = ADJ_INC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp        <= '0;
      live_count <= '0;
    end else begin
      case (move)
        WIN_PUSH: begin
          cwp        <= (cwp == TOP) ? ZERO : cwp + 1'b1;
          live_count <= live_count + 1'b1;
        end
        WIN_POP: begin
          cwp        <= (cwp == ZERO) ? TOP : cwp - 1'b1;
          live_count <= live_count - 1'b1;
        end
        default: begin
          case (adj)
            ADJ_DEC: live_count <= live_count - 1'b1;
            ADJ_INC: live_count <= live_count + 1'b1;
            default: live_count <= live_count;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  parameter int unsigned NRD  = 2,
  localparam int unsigned CW  = $clog2(NWIN),
  localparam int unsigned RW  = CW + IDX_W,
  localparam int unsigned DEPTH = NWIN * ARCH_REGS
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RW-1:0]   wr_row,
  input  logic [XLEN-1:0] wr_word,
  input  logic [RW-1:0]   rd_row  [NRD],
  output logic [XLEN-1:0] rd_word [NRD]
);
  logic [XLEN-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wr_row] <= wr_word;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_word[p] = store[rd_row[p]];
  end
endmodule

// File: rtl/regwin_rdport.sv
module regwin_rdport
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned CW  = $clog2(NWIN),
  localparam int unsigned RW  = CW + IDX_W
) (
  input  logic [CW-1:0]    win,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  bank_word,
  output logic [RW-1:0]    row,
  output logic [XLEN-1:0]  data
);
  assign row  = {win, idx};
  assign data = (idx == '0) ? '0 : bank_word;
endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned CW  = $clog2(NWIN),
  localparam int unsigned RW  = CW + IDX_W,
  localparam int unsigned NRD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_req,
  input  logic            ret_req,
  input  logic            spill_done,
  input  logic            fill_done,
  input  logic [4:0]      rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [4:0]      rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  output logic [CW-1:0]   cwp,
  output logic [CW-1:0]   live_count,
  output logic            overflow,
  output logic            underflow
);
  logic [IDX_W-1:0] rd_idx  [NRD];
  logic [RW-1:0]    rd_row  [NRD];
  logic [XLEN-1:0]  rd_word [NRD];
  logic [XLEN-1:0]  rd_val  [NRD];

  assign rd_idx[0] = rd_addr_a;
  assign rd_idx[1] = rd_addr_b;
  assign rd_data_a = rd_val[0];
  assign rd_data_b = rd_val[1];

  regwin_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .spill_done (spill_done),
    .fill_done  (fill_done),
    .cwp        (cwp),
    .live_count (live_count),
    .overflow   (overflow),
    .underflow  (underflow)
  );

  // Write uses the pointer value of this cycle, i.e. before any move
  regwin_bank #(.NWIN(NWIN), .XLEN(XLEN), .NRD(NRD)) u_bank (
    .clk     (clk),
    .we      (wr_en && (wr_addr != '0)),
    .wr_row  ({cwp, wr_addr}),
    .wr_word (wr_data),
    .rd_row  (rd_row),
    .rd_word (rd_word)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    regwin_rdport #(.NWIN(NWIN), .XLEN(XLEN)) u_rd (
      .win       (cwp),
      .idx       (rd_idx[p]),
      .bank_word (rd_word[p]),
      .row       (rd_row[p]),
      .data      (rd_val[p])
    );
  end
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW  = $clog2(NWIN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_req,
  input logic          ret_req,
  input logic          overflow,
  input logic          underflow,
  input logic [CW-1:0] cwp,
  input logic [CW-1:0] live_count
);
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  function automatic logic [CW-1:0] fwd(input logic [CW-1:0] w);
    return (w == TOP) ? '0 : w + 1'b1;
  endfunction
  function automatic logic [CW-1:0] back(input logic [CW-1:0] w);
    return (w == '0) ? TOP : w - 1'b1;
  endfunction

  p_call_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !overflow) |=> (cwp == fwd($past(cwp)) && live_count == $past(live_count) + 1'b1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (cwp == $past(cwp)));

  p_overflow_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (call_req && live_count == TOP));

  p_underflow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (cwp == $past(cwp)));

  p_ret_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && !underflow) |=> (cwp == back($past(cwp)) && live_count == $past(live_count) - 1'b1));

  p_call_masks_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !underflow);

  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live_count <= TOP);
endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN)) u_chk (.*);

// File: tb/tb_regwin_file.sv
`timescale 1ns/1ps
module tb_regwin_file;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int CW   = $clog2(NWIN);

  logic clk = 1'b0, rst_n = 1'b0;
  logic call_req = 0, ret_req = 0, spill_done = 0, fill_done = 0, wr_en = 0;
  logic [4:0] rd_addr_a = 0, rd_addr_b = 0, wr_addr = 0;
  logic [XLEN-1:0] wr_data = 0, rd_data_a, rd_data_b;
  logic [CW-1:0] cwp, live_count;
  logic overflow, underflow;

  int n_checks = 0, n_fail = 0;

  // Reference state
  logic [XLEN-1:0] m_reg [NWIN][32];
  bit              m_val [NWIN][32];
  int              m_cwp = 0, m_cnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  regwin_file #(.NWIN(NWIN), .XLEN(XLEN)) dut (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ovf(bit c, int cnt);
    return c && cnt == NWIN-1;
  endfunction
  function automatic bit exp_unf(bit c, bit r, int cnt);
    return !c && r && cnt == 0;
  endfunction

  // One cycle: drive after negedge, check combinational outputs, advance model
  task automatic step(input bit c, input bit r, input bit sp, input bit fl,
                      input bit we, input int wa, input logic [XLEN-1:0] wd,
                      input int ra, input int rb);
    bit go_c, go_r;
    @(negedge clk);
    call_req = c; ret_req = r; spill_done = sp; fill_done = fl;
    wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
    #1;
    chk("R2/R5 cwp", cwp, m_cwp);
    chk("R8 live_count", live_count, m_cnt);
    chk("R3 overflow", overflow, exp_ovf(c, m_cnt));
    chk("R4/R6 underflow", underflow, exp_unf(c, r, m_cnt));
    if (ra == 0) chk("R1 read A idx0", rd_data_a, 0);
    else if (m_val[m_cwp][ra]) chk("R7 read A", rd_data_a, m_reg[m_cwp][ra]);
    if (rb == 0) chk("R1 read B idx0", rd_data_b, 0);
    else if (m_val[m_cwp][rb]) chk("R7 read B", rd_data_b, m_reg[m_cwp][rb]);
    // model update
    if (we && wa != 0) begin m_reg[m_cwp][wa] = wd; m_val[m_cwp][wa] = 1; end
    go_c = c && m_cnt != NWIN-1;
    go_r = !c && r && m_cnt != 0;
    if (go_c) begin m_cwp = (m_cwp + 1) % NWIN; m_cnt++; end
    else if (go_r) begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_cnt--; end
    else if (sp) begin if (m_cnt != 0) m_cnt--; end
    else if (fl && m_cnt != NWIN-1) m_cnt++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h1A2B;
    void'($urandom(seed));
    foreach (m_val[w, i]) m_val[w][i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 cwp at reset", cwp, 0);
    chk("R9 count at reset", live_count, 0);
    chk("R9 overflow at reset", overflow, 0);
    chk("R9 underflow at reset", underflow, 0);
    @(negedge clk); rst_n = 1'b1;

    // R4 underflow on return at empty; R1 write to index 0
    step(0,1,0,0, 1,0,32'hDEAD_BEEF, 0,0);
    step(0,0,0,0, 1,5,32'h0000_0055, 0,5);
    // R7 write on same edge as a call lands in old window
    step(1,0,0,0, 1,6,32'h0000_0066, 5,6);
    step(0,0,0,0, 1,6,32'h0000_0777, 6,5);   // window 1 private
    step(0,1,0,0, 0,0,0, 6,6);               // return
    step(0,0,0,0, 0,0,0, 6,5);               // back in window 0
    // fill R3 overflow: climb to full
    for (int i = 0; i < NWIN; i++) step(1,0,0,0, 0,0,0, 1,2);
    // R6 call+return while full: overflow, return ignored
    step(1,1,0,0, 0,0,0, 5,6);
    // R8 spill during overflow, then retry the call
    step(1,0,1,1, 0,0,0, 5,6);
    step(1,0,0,0, 0,0,0, 5,6);
    // R8 spill precedence and ignore when accepted call
    for (int i = 0; i < NWIN; i++) step(0,0,1,1, 0,0,0, 3,4);
    step(0,0,1,0, 0,0,0, 3,4);                 // spill at zero: ignored
    step(1,1,0,0, 0,0,0, 3,4);                 // R6 call wins at empty
    step(0,1,0,0, 0,0,0, 3,4);
    step(0,1,0,1, 0,0,0, 3,4);                 // R4 underflow, fill counts

    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      bit c, r, sp, fl, we;
      c  = ($urandom % 100) < 35;
      r  = ($urandom % 100) < 35;
      sp = ($urandom % 100) < 15;
      fl = ($urandom % 100) < 15;
      we = ($urandom % 100) < 50;
      step(c, r, sp, fl, we, $urandom % 32, $urandom,
           $urandom % 32, $urandom % 32);
    end
    step(0,0,0,0, 0,0,0, 0,0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule